// File: doc/BRIEF.md
# Serial Controller Register Access Sequencer

This block is the processor-facing register file of a serial communications controller. A host access is described by an active-low chip select, a two-bit register address, a write/read select and an eight-bit write value, and it takes effect on a single-cycle access strobe of the system clock. Reads are answered combinationally on an eight-bit return path, together with a drive enable that tells the bus pad when to drive it.

Two addresses are shared by several registers. Behind the sync address sit three write-only characters: the first sync character, the second sync character and the data-link-escape character. Behind the mode address sit two mode registers that can be read and written. An internal pointer for each address advances after every access to that address and wraps around. Both pointers return to their first register only on reset or on a read of the command register. This lets software re-align its view of the shared addresses without a dedicated index register.

The block holds the command register and drives the modem-control outputs from it. It assembles the status byte from sticky receive-error flags, registered carrier and data-set inputs and live flags from the datapaths. It also gives the transmitter and receiver their register values and single-cycle pulses: holding-register loaded, receive holding register taken, and error flags cleared.

Top module: `sio_regbank`

## Requirements
- R1: While `cs_n` is high, `rdata_oe` is low, `rdata` is zero, and an `acc_stb` changes no register. `rdata_oe` is high exactly when `cs_n` is low and `wr_en` is low.
- R2: Address decode (`wr_en` 1 = write). Address 00 read returns `rhr_data`. Address 00 write captures `wdata` into `thr_q` and raises `thr_load` for the one cycle after the strobe. Address 01 read returns status, and 01 write loads the sync chain. Address 10 reads or writes the mode register the mode pointer selects. Address 11 reads or writes the command register.
- R3: Successive writes to address 01 load `syn1_q`, then `syn2_q`, then `dle_q`, and then start again at `syn1_q`.
- R4: Successive accesses to address 10, whether reads or writes, select mode register 1 and then mode register 2, then wrap. Each access advances the pointer once.
- R5: Both pointers return to their first register on reset and on a command read. A status read, a receive-holding read, a transmit-holding write or a command write leaves them unchanged.
- R6: Reset clears both mode registers, the command register and the three error flags, so `dtr_n` and `rts_n` are high.
- R7: Command bit 4 is never stored and always reads as 0. Writing it as 1 clears the framing, overrun and parity flags and raises `err_clr` for the one cycle after the strobe. A set pulse in the same cycle as the clear wins.
- R8: `dtr_n` is the complement of command bit 1 and `rts_n` is the complement of command bit 5.
- R9: Status bits, from bit 7 down to bit 0, are: data-set ready (1 when `dsr_n` is low), carrier detect (1 when `dcd_n` is low), framing flag, overrun flag, parity flag, `tx_emt`, `rx_rdy`, `tx_rdy`. The two modem bits follow their input one cycle later. The error flags are sticky and set by `fe_set`, `oe_set` and `pe_set`.
- R10: A read of address 00 raises `rhr_taken` for the one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_stb | input | 1 | Single-cycle access strobe |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 2 | Register address |
| wr_en | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write value |
| rdata | output | 8 | Read value, zero when not driven |
| rdata_oe | output | 1 | Return-path drive enable |
| rhr_data | input | 8 | Receive holding register from receiver |
| rx_rdy | input | 1 | Receiver holding register full |
| tx_rdy | input | 1 | Transmit holding register empty |
| tx_emt | input | 1 | Transmitter empty or modem change |
| fe_set | input | 1 | Framing error pulse |
| oe_set | input | 1 | Overrun error pulse |
| pe_set | input | 1 | Parity/escape-detect pulse |
| dcd_n | input | 1 | Carrier detect input, active low |
| dsr_n | input | 1 | Data set ready input, active low |
| syn1_q | output | 8 | First sync character |
| syn2_q | output | 8 | Second sync character |
| dle_q | output | 8 | Escape character |
| mode1_q | output | 8 | Mode register 1 |
| mode2_q | output | 8 | Mode register 2 |
| cmd_q | output | 8 | Command register (bit 4 always 0) |
| thr_q | output | 8 | Transmit holding value |
| thr_load | output | 1 | Transmit holding loaded pulse |
| rhr_taken | output | 1 | Receive holding read pulse |
| err_clr | output | 1 | Error flags cleared pulse |
| dtr_n | output | 1 | Terminal ready output |
| rts_n | output | 1 | Request to send output |

## Verification
A pointer that has drifted cannot be seen at once. It shows up on the next shared-address access: a mode read returns the other register's value, or a sync write lands on the wrong character output in the cycle after its strobe. Because of this, the bench interleaves unrelated accesses between mode and sync accesses, and then reads back or observes the outputs. A stored error-reset bit or a missed flag clear shows on the very next command or status read. Modem outputs and pulses are sampled in the first cycle after the strobe edge.

// File: rtl/sio_regbank_pkg.sv
package sio_regbank_pkg;

  typedef enum logic [1:0] {
    A_DATA = 2'b00,
    A_SYNC = 2'b01,
    A_MODE = 2'b10,
    A_CMD  = 2'b11
  } reg_addr_e;

  localparam int CB_DTR    = 1;
  localparam int CB_ERRCLR = 4;
  localparam int CB_RTS    = 5;

  typedef struct packed {
    logic thr_wr;
    logic rhr_rd;
    logic stat_rd;
    logic sync_wr;
    logic mode_acc;
    logic mode_wr;
    logic cmd_rd;
    logic cmd_wr;
  } acc_ev_t;

endpackage

// File: rtl/sio_acc_decode.sv
module sio_acc_decode
  import sio_regbank_pkg::*;
(
  input  logic       acc_stb,
  input  logic       cs_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  output acc_ev_t    ev
);

  logic live;

  always_comb begin
    live        = acc_stb & ~cs_n;
    ev          = '0;
    ev.thr_wr   = live &  wr_en & (addr == A_DATA);
    ev.rhr_rd   = live & ~wr_en & (addr == A_DATA);
    ev.stat_rd  = live & ~wr_en & (addr == A_SYNC);
    ev.sync_wr  = live &  wr_en & (addr == A_SYNC);
    ev.mode_acc = live &          (addr == A_MODE);
    ev.mode_wr  = live &  wr_en & (addr == A_MODE);
    ev.cmd_rd   = live & ~wr_en & (addr == A_CMD);
    ev.cmd_wr   = live &  wr_en & (addr == A_CMD);
  end

endmodule

// File: rtl/sio_ptr_seq.sv
module sio_ptr_seq #(
  parameter int NREG = 3,
  parameter int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [IW-1:0] idx_q
);

  localparam logic [IW-1:0] LAST = IW'(NREG - 1);

  logic [IW-1:0] idx_d;
  logic          idx_en;

  always_comb begin
    idx_en = adv | clr;
    idx_d  = idx_q;
    if (clr)
      idx_d = '0;
    else if (adv)
      idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_en)
      idx_q <= idx_d;
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx_q == '0)); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(idx_q)); // R5

endmodule

// File: rtl/sio_stat_reg.sv
module sio_stat_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fe_set,
  input  logic       oe_set,
  input  logic       pe_set,
  input  logic       clr,
  input  logic       dcd_n,
  input  logic       dsr_n,
  output logic [2:0] err_q,
  output logic       dcd_q,
  output logic       dsr_q
);

  logic [2:0] set_v;
  logic [2:0] err_d;

  always_comb begin
    set_v = {fe_set, oe_set, pe_set};
    err_d = (clr ? 3'b000 : err_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      dcd_q <= 1'b0;
      dsr_q <= 1'b0;
    end else begin
      err_q <= err_d;
      dcd_q <= ~dcd_n;
      dsr_q <= ~dsr_n;
    end
  end

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fe_set && !oe_set && !pe_set) |=> (err_q == 3'b000)); // R7

endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_regbank_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NSYNC = 3,
  parameter int NMODE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_stb,
  input  logic          cs_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  input  logic [DW-1:0] rhr_data,
  input  logic          rx_rdy,
  input  logic          tx_rdy,
  input  logic          tx_emt,
  input  logic          fe_set,
  input  logic          oe_set,
  input  logic          pe_set,
  input  logic          dcd_n,
  input  logic          dsr_n,
  output logic [DW-1:0] syn1_q,
  output logic [DW-1:0] syn2_q,
  output logic [DW-1:0] dle_q,
  output logic [DW-1:0] mode1_q,
  output logic [DW-1:0] mode2_q,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] thr_q,
  output logic          thr_load,
  output logic          rhr_taken,
  output logic          err_clr,
  output logic          dtr_n,
  output logic          rts_n
);

  localparam int SIW = (NSYNC > 1) ? $clog2(NSYNC) : 1;
  localparam int MIW = (NMODE > 1) ? $clog2(NMODE) : 1;

  acc_ev_t        ev;
  logic [SIW-1:0] sptr;
  logic [MIW-1:0] mptr;
  logic [DW-1:0]  syn_q  [NSYNC];
  logic [DW-1:0]  mode_q [NMODE];
  logic [DW-1:0]  cmd_d;
  logic [DW-1:0]  stat_v;
  logic [2:0]     err_q;
  logic           dcd_q;
  logic           dsr_q;
  logic           errclr_cmd;

  sio_acc_decode u_dec (
    .acc_stb (acc_stb),
    .cs_n    (cs_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .ev      (ev)
  );

  sio_ptr_seq #(.NREG(NSYNC), .IW(SIW)) u_sptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ev.sync_wr),
    .clr   (ev.cmd_rd),
    .idx_q (sptr)
  );

  sio_ptr_seq #(.NREG(NMODE), .IW(MIW)) u_mptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ev.mode_acc),
    .clr   (ev.cmd_rd),
    .idx_q (mptr)
  );

  always_comb errclr_cmd = ev.cmd_wr & wdata[CB_ERRCLR];

  sio_stat_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .fe_set (fe_set),
    .oe_set (oe_set),
    .pe_set (pe_set),
    .clr    (errclr_cmd),
    .dcd_n  (dcd_n),
    .dsr_n  (dsr_n),
    .err_q  (err_q),
    .dcd_q  (dcd_q),
    .dsr_q  (dsr_q)
  );

  for (genvar gi = 0; gi < NSYNC; gi++) begin : g_syn
    logic syn_en;
    always_comb syn_en = ev.sync_wr & (sptr == SIW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        syn_q[gi] <= '0;
      else if (syn_en)
        syn_q[gi] <= wdata;
    end
  end

  for (genvar gm = 0; gm < NMODE; gm++) begin : g_mode
    logic mode_en;
    always_comb mode_en = ev.mode_wr & (mptr == MIW'(gm));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mode_q[gm] <= '0;
      else if (mode_en)
        mode_q[gm] <= wdata;
    end
  end

  always_comb begin
    cmd_d             = wdata;
    cmd_d[CB_ERRCLR]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmd_q <= '0;
    else if (ev.cmd_wr)
      cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      thr_q <= '0;
    else if (ev.thr_wr)
      thr_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_load  <= 1'b0;
      rhr_taken <= 1'b0;
      err_clr   <= 1'b0;
    end else begin
      thr_load  <= ev.thr_wr;
      rhr_taken <= ev.rhr_rd;
      err_clr   <= errclr_cmd;
    end
  end

  always_comb begin
    syn1_q  = syn_q[0];
    syn2_q  = syn_q[1];
    dle_q   = syn_q[2];
    mode1_q = mode_q[0];
    mode2_q = mode_q[1];
    dtr_n   = ~cmd_q[CB_DTR];
    rts_n   = ~cmd_q[CB_RTS];
  end

  always_comb begin
    stat_v   = {dsr_q, dcd_q, err_q, tx_emt, rx_rdy, tx_rdy};
    rdata_oe = ~cs_n & ~wr_en;
    rdata    = '0;
    if (rdata_oe) begin
      case (addr)
        A_DATA:  rdata = rhr_data;
        A_SYNC:  rdata = stat_v;
        A_MODE:  rdata = mode_q[mptr];
        default: rdata = cmd_q;
      endcase
    end
  end

  AST_THR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |-> (thr_q == $past(wdata))); // R2

endmodule

// File: tb/sio_regbank_tb.sv
module sio_regbank_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_stb, cs_n, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, rhr_data;
  logic       rdata_oe;
  logic       rx_rdy, tx_rdy, tx_emt, fe_set, oe_set, pe_set, dcd_n, dsr_n;
  logic [7:0] syn1_q, syn2_q, dle_q, mode1_q, mode2_q, cmd_q, thr_q;
  logic       thr_load, rhr_taken, err_clr, dtr_n, rts_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  sio_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .cs_n(cs_n), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .rhr_data(rhr_data), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .tx_emt(tx_emt),
    .fe_set(fe_set), .oe_set(oe_set), .pe_set(pe_set), .dcd_n(dcd_n),
    .dsr_n(dsr_n), .syn1_q(syn1_q), .syn2_q(syn2_q), .dle_q(dle_q),
    .mode1_q(mode1_q), .mode2_q(mode2_q), .cmd_q(cmd_q), .thr_q(thr_q),
    .thr_load(thr_load), .rhr_taken(rhr_taken), .err_clr(err_clr),
    .dtr_n(dtr_n), .rts_n(rts_n)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // one access: drive at negedge, sample read value before the strobe edge
  task automatic acc(input logic [1:0] a, input logic w, input logic [7:0] d,
                     output logic [7:0] rd);
    @(negedge clk);
    cs_n = 1'b0; addr = a; wr_en = w; wdata = d; acc_stb = 1'b1;
    #1 rd = rdata;
    @(posedge clk);
    #1;
    acc_stb = 1'b0; cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    chk("R6 dtr_n after reset", {7'd0, dtr_n}, 8'h01);
    chk("R6 rts_n after reset", {7'd0, rts_n}, 8'h01);
    chk("R1 oe idle", {7'd0, rdata_oe}, 8'h00);
    acc(2'b11, 1'b0, 8'h00, r);
    chk("R6 cmd after reset", r, 8'h00);
    acc(2'b10, 1'b0, 8'h00, r);
    chk("R6 mode1 after reset", r, 8'h00);
    acc(2'b10, 1'b0, 8'h00, r);
    chk("R6 mode2 after reset", r, 8'h00);
    acc(2'b01, 1'b0, 8'h00, r);
    chk("R6 error flags after reset", r & 8'h38, 8'h00);
  endtask

  task automatic t_bus;
    @(negedge clk);
    cs_n = 1'b1; addr = 2'b11; wr_en = 1'b1; wdata = 8'hFF; acc_stb = 1'b1;
    #1;
    chk("R1 oe with cs high", {7'd0, rdata_oe}, 8'h00);
    chk("R1 rdata with cs high", rdata, 8'h00);
    @(posedge clk); #1 acc_stb = 1'b0;
    chk("R1 strobe without cs ignored", {6'd0, dtr_n, rts_n}, 8'h03);
    @(negedge clk);
    cs_n = 1'b0; wr_en = 1'b1; #1;
    chk("R1 oe on write", {7'd0, rdata_oe}, 8'h00);
    wr_en = 1'b0; #1;
    chk("R1 oe on read", {7'd0, rdata_oe}, 8'h01);
    cs_n = 1'b1;
  endtask

  task automatic t_sync;
    logic [7:0] r;
    acc(2'b11, 1'b0, 8'h00, r);
    acc(2'b01, 1'b1, 8'hA1, r);
    acc(2'b01, 1'b1, 8'hA2, r);
    acc(2'b01, 1'b1, 8'hA3, r);
    chk("R3 syn1", syn1_q, 8'hA1);
    chk("R3 syn2", syn2_q, 8'hA2);
    chk("R3 dle", dle_q, 8'hA3);
    acc(2'b01, 1'b1, 8'hA4, r);
    chk("R3 wrap to syn1", syn1_q, 8'hA4);
    chk("R3 syn2 untouched on wrap", syn2_q, 8'hA2);
  endtask

  task automatic t_mode;
    logic [7:0] r;
    acc(2'b11, 1'b0, 8'h00, r);
    acc(2'b10, 1'b1, 8'h4E, r);
    acc(2'b10, 1'b1, 8'h37, r);
    chk("R4 mode1 out", mode1_q, 8'h4E);
    chk("R4 mode2 out", mode2_q, 8'h37);
    acc(2'b10, 1'b0, 8'h00, r);
    chk("R4 read mode1 after wrap", r, 8'h4E);
    acc(2'b10, 1'b0, 8'h00, r);
    chk("R4 read mode2", r, 8'h37);
    acc(2'b10, 1'b0, 8'h00, r);
    chk("R4 read wraps to mode1", r, 8'h4E);
  endtask

  task automatic t_ptr;
    logic [7:0] r;
    acc(2'b11, 1'b0, 8'h00, r);
    acc(2'b10, 1'b1, 8'h11, r);
    acc(2'b01, 1'b0, 8'h00, r);
    acc(2'b00, 1'b1, 8'h5C, r);
    acc(2'b00, 1'b0, 8'h00, r);
    acc(2'b11, 1'b1, 8'h00, r);
    acc(2'b10, 1'b0, 8'h00, r);
    chk("R5 mode ptr kept over other accesses", r, 8'h37);
    acc(2'b11, 1'b0, 8'h00, r);
    acc(2'b10, 1'b0, 8'h00, r);
    chk("R5 cmd read resets mode ptr", r, 8'h11);
    acc(2'b01, 1'b1, 8'hB1, r);
    acc(2'b11, 1'b0, 8'h00, r);
    acc(2'b01, 1'b1, 8'hB2, r);
    chk("R5 cmd read resets sync ptr", syn1_q, 8'hB2);
    chk("R5 syn2 kept", syn2_q, 8'hA2);
  endtask

  task automatic t_cmd;
    logic [7:0] r;
    acc(2'b11, 1'b1, 8'h22, r);
    chk("R8 dtr_n low", {7'd0, dtr_n}, 8'h00);
    chk("R8 rts_n low", {7'd0, rts_n}, 8'h00);
    acc(2'b11, 1'b0, 8'h00, r);
    chk("R2 cmd readback", r, 8'h22);
    acc(2'b11, 1'b1, 8'h02, r);
    chk("R8 rts_n high", {7'd0, rts_n}, 8'h01);
    chk("R8 dtr_n still low", {7'd0, dtr_n}, 8'h00);
  endtask

  task automatic t_err;
    logic [7:0] r;
    @(negedge clk); fe_set = 1'b1; oe_set = 1'b1; pe_set = 1'b1;
    @(negedge clk); fe_set = 1'b0; oe_set = 1'b0; pe_set = 1'b0;
    acc(2'b01, 1'b0, 8'h00, r);
    chk("R9 sticky error flags", r & 8'h38, 8'h38);
    acc(2'b11, 1'b1, 8'h12, r);
    chk("R7 err_clr pulse", {7'd0, err_clr}, 8'h01);
    @(posedge clk); #1;
    chk("R7 err_clr one cycle", {7'd0, err_clr}, 8'h00);
    acc(2'b01, 1'b0, 8'h00, r);
    chk("R7 flags cleared", r & 8'h38, 8'h00);
    acc(2'b11, 1'b0, 8'h00, r);
    chk("R7 bit4 not stored", r, 8'h02);
    // set and clear in the same cycle: set wins
    @(negedge clk);
    cs_n = 1'b0; addr = 2'b11; wr_en = 1'b1; wdata = 8'h10; acc_stb = 1'b1; oe_set = 1'b1;
    @(posedge clk); #1;
    acc_stb = 1'b0; cs_n = 1'b1; wr_en = 1'b0; oe_set = 1'b0;
    acc(2'b01, 1'b0, 8'h00, r);
    chk("R7 set beats clear", r & 8'h38, 8'h10);
  endtask

  task automatic t_status;
    logic [7:0] r;
    @(negedge clk);
    dsr_n = 1'b0; dcd_n = 1'b1; tx_rdy = 1'b1; rx_rdy = 1'b0; tx_emt = 1'b1;
    @(negedge clk);
    acc(2'b01, 1'b0, 8'h00, r);
    chk("R9 status dsr low", r & 8'hC7, 8'h85);
    @(negedge clk);
    dsr_n = 1'b1; dcd_n = 1'b0; tx_rdy = 1'b0; rx_rdy = 1'b1; tx_emt = 1'b0;
    @(negedge clk);
    acc(2'b01, 1'b0, 8'h00, r);
    chk("R9 status dcd low", r & 8'hC7, 8'h42);
  endtask

  task automatic t_data;
    logic [7:0] r;
    acc(2'b00, 1'b1, 8'h9D, r);
    chk("R2 thr value", thr_q, 8'h9D);
    chk("R2 thr_load pulse", {7'd0, thr_load}, 8'h01);
    @(posedge clk); #1;
    chk("R2 thr_load one cycle", {7'd0, thr_load}, 8'h00);
    rhr_data = 8'h5A;
    acc(2'b00, 1'b0, 8'h00, r);
    chk("R2 rhr read", r, 8'h5A);
    chk("R10 rhr_taken pulse", {7'd0, rhr_taken}, 8'h01);
    @(posedge clk); #1;
    chk("R10 rhr_taken one cycle", {7'd0, rhr_taken}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_stb = 1'b0; cs_n = 1'b1; wr_en = 1'b0; addr = 2'b00;
    wdata = 8'h00; rhr_data = 8'h00; rx_rdy = 1'b0; tx_rdy = 1'b0; tx_emt = 1'b0;
    fe_set = 1'b0; oe_set = 1'b0; pe_set = 1'b0; dcd_n = 1'b1; dsr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus();
    t_sync();
    t_mode();
    t_ptr();
    t_cmd();
    t_err();
    t_status();
    t_data();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule